// File: doc/BRIEF.md
# Multi-Cycle Signed/Unsigned Integer Divider

This block divides a double-width dividend by a single-width divisor and returns a single-width quotient and remainder. The divisor width is picked per operation from three sizes (a quarter, a half or the full `DW` bits, which is 8, 16 or 32 with the default `DW` = 32). A mode bit selects unsigned or two's-complement signed operation. One quotient bit is produced per clock by a restoring shift-subtract loop that works on magnitudes. Signs are applied in a correction step after the loop.

A caller drives the operands and raises `start` while the block is idle. `busy` then stays high until the one-cycle `done` pulse. When `done` is high, the quotient, the remainder and `div_err` are ready, and they hold their values until the next accepted start. `div_err` reports a zero divisor and also a quotient that does not fit the selected width. Both faults use the same flag, and on either one the quotient and remainder outputs read zero.

The control is a four-state machine. ST_IDLE waits for `start`. On start it goes to ST_RUN for a nonzero divisor, or straight to ST_DONE for a zero divisor. ST_RUN stays for 2W steps and then goes to ST_FIX. ST_FIX applies signs, checks for overflow and goes to ST_DONE. ST_DONE raises `done` and returns to ST_IDLE.

Top module: `int_divider`

## Requirements
- R1: The `size` code 2'b00 selects W = DW/4, 2'b01 selects W = DW/2, and 2'b10 or 2'b11 selects W = DW. Only the low 2W bits of `dividend` and the low W bits of `divisor` take part, and higher input bits have no effect on any output.
- R2: In unsigned mode (`is_signed` = 0), the quotient is floor(dividend/divisor) and the remainder is dividend mod divisor. Both are placed in the low W bits of their outputs, and the bits above W read zero.
- R3: In signed mode (`is_signed` = 1), the operands are two's complement at widths 2W and W. The quotient truncates toward zero and is returned as a W-bit two's-complement value.
- R4: In signed mode, the remainder carries the sign of the dividend (a zero remainder reads zero), and quotient*divisor + remainder equals the dividend.
- R5: A divisor whose low W bits are all zero sets `div_err`, and `done` is high in the first cycle after the start edge.
- R6: In unsigned mode, a quotient of 2^W or more sets `div_err`.
- R7: In signed mode, a quotient outside the range -2^(W-1) to 2^(W-1)-1 sets `div_err`. The value -2^(W-1) itself is legal.
- R8: While `div_err` is set after `done`, `quotient` and `remainder` read zero.
- R9: For a nonzero divisor, `done` is a single-cycle pulse that is high 2W+1 cycles after the clock edge that accepted `start`.
- R10: `busy` is high from the cycle after an accepted start through the `done` cycle, and low otherwise.
- R11: `start` has no effect while `busy` is high. The running operation completes with the operands it was started with.
- R12: `quotient`, `remainder` and `div_err` hold their values from `done` until the next accepted start. Reset clears all of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a division when idle |
| dividend | input | 2*DW | Double-width dividend (low 2W bits used) |
| divisor | input | DW | Divisor (low W bits used) |
| size | input | 2 | Width select: 00 quarter, 01 half, 10/11 full |
| is_signed | input | 1 | 1 = two's-complement division |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| div_err | output | 1 | Zero divisor or quotient overflow |
| quotient | output | DW | Quotient, zero-extended above W |
| remainder | output | DW | Remainder, zero-extended above W |

## Verification
The bench targets the signed boundary, where a quotient of exactly -2^(W-1) must pass while +2^(W-1) must fail. An off-by-one in the overflow limits either rejects the legal minimum or accepts the overflow. Mixed-sign operands check that the remainder follows the dividend and not the divisor; a design that floors instead of truncating returns a quotient one step too negative with a remainder of the wrong sign. Garbage placed above the selected width, a second start pulse during a run, and the exact cycle of `done` for each size and for a zero divisor expose width-masking mistakes, a restart in flight and a wrong iteration count.

// File: rtl/idiv_pkg.sv
package idiv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_FIX,
        ST_DONE
    } idiv_state_e;

    typedef enum logic [1:0] {
        SZ_QUARTER  = 2'b00,
        SZ_HALF     = 2'b01,
        SZ_FULL     = 2'b10,
        SZ_FULL_ALT = 2'b11
    } idiv_size_e;

    // Divisor width selected by the size code for a maximum width dw.
    function automatic int unsigned width_of(input logic [1:0] sz, input int unsigned dw);
        case (sz)
            SZ_QUARTER: return dw / 4;
            SZ_HALF:    return dw / 2;
            default:    return dw;
        endcase
    endfunction

endpackage

// File: rtl/idiv_operand_prep.sv
module idiv_operand_prep #(
    parameter int unsigned DW = 32,
    localparam int unsigned NW = 2 * DW,
    localparam int unsigned CW = $clog2(NW + 1)
) (
    input  logic [NW-1:0] dividend,
    input  logic [DW-1:0] divisor,
    input  logic [1:0]    size,
    input  logic          is_signed,
    output logic [NW-1:0] aligned,
    output logic [DW-1:0] dvs_mag,
    output logic          neg_q,
    output logic          neg_r,
    output logic          zero_div,
    output logic [CW-1:0] iters
);
    import idiv_pkg::*;

    int unsigned   w;
    logic [NW-1:0] mask_n;
    logic [DW-1:0] mask_d;
    logic [NW-1:0] dd;
    logic [DW-1:0] vv;
    logic [NW-1:0] dmag;
    logic          sd;
    logic          sv;

    always_comb begin
        w      = width_of(size, DW);
        mask_n = (2 * w >= NW) ? '1 : ((NW'(1) << (2 * w)) - NW'(1));
        mask_d = (w >= DW) ? '1 : ((DW'(1) << w) - DW'(1));
        dd     = dividend & mask_n;
        vv     = divisor & mask_d;
        sd     = is_signed & dd[2 * w - 1];
        sv     = is_signed & vv[w - 1];
        dmag   = sd ? ((~dd + NW'(1)) & mask_n) : dd;
        dvs_mag = sv ? ((~vv + DW'(1)) & mask_d) : vv;
        // Put the magnitude at the top so the loop always reads bit NW-1.
        aligned  = dmag << (NW - 2 * w);
        neg_q    = sd ^ sv;
        neg_r    = sd;
        zero_div = (vv == '0);
        iters    = CW'(2 * w);
    end

endmodule

// File: rtl/idiv_shift_sub.sv
module idiv_shift_sub #(
    parameter int unsigned DW = 32,
    localparam int unsigned NW = 2 * DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic [NW-1:0] aligned,
    input  logic [DW-1:0] dvs,
    output logic [NW-1:0] qmag,
    output logic [DW-1:0] rmag
);
    logic [NW-1:0] dq_r;
    logic [DW-1:0] rem_r;
    logic [DW-1:0] vs_r;
    logic [DW:0]   trial;
    logic [DW+1:0] diff;
    logic          fits;

    always_comb begin
        trial = {rem_r, dq_r[NW-1]};
        diff  = {1'b0, trial} - {2'b00, vs_r};
        fits  = ~diff[DW+1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dq_r  <= '0;
            rem_r <= '0;
            vs_r  <= '0;
        end else if (load) begin
            dq_r  <= aligned;
            rem_r <= '0;
            vs_r  <= dvs;
        end else if (step) begin
            dq_r  <= {dq_r[NW-2:0], fits};
            rem_r <= fits ? diff[DW-1:0] : trial[DW-1:0];
        end
    end

    assign qmag = dq_r;
    assign rmag = rem_r;

endmodule

// File: rtl/idiv_result_fix.sv
module idiv_result_fix #(
    parameter int unsigned DW = 32,
    localparam int unsigned NW = 2 * DW
) (
    input  logic [NW-1:0] qmag,
    input  logic [DW-1:0] rmag,
    input  logic [1:0]    size,
    input  logic          is_signed,
    input  logic          neg_q,
    input  logic          neg_r,
    output logic [DW-1:0] quo,
    output logic [DW-1:0] rem,
    output logic          ovf
);
    import idiv_pkg::*;

    int unsigned   w;
    logic [NW-1:0] hi;
    logic [NW-1:0] low;
    logic [DW-1:0] mask_d;
    logic [DW-1:0] qs;
    logic [DW-1:0] rs;

    always_comb begin
        w      = width_of(size, DW);
        mask_d = (w >= DW) ? '1 : ((DW'(1) << w) - DW'(1));
        hi     = qmag >> (w - 1);
        low    = qmag & ((NW'(1) << (w - 1)) - NW'(1));
        if (!is_signed) begin
            ovf = (qmag >> w) != '0;
        end else if (neg_q) begin
            ovf = (hi > NW'(1)) || (hi == NW'(1) && low != '0);
        end else begin
            ovf = hi != '0;
        end
        qs  = neg_q ? (~qmag[DW-1:0] + DW'(1)) : qmag[DW-1:0];
        rs  = neg_r ? (~rmag + DW'(1)) : rmag;
        quo = qs & mask_d;
        rem = rs & mask_d;
    end

endmodule

// File: rtl/int_divider.sv
module int_divider #(
    parameter int unsigned DW = 32,
    localparam int unsigned NW = 2 * DW,
    localparam int unsigned CW = $clog2(NW + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [NW-1:0] dividend,
    input  logic [DW-1:0] divisor,
    input  logic [1:0]    size,
    input  logic          is_signed,
    output logic          busy,
    output logic          done,
    output logic          div_err,
    output logic [DW-1:0] quotient,
    output logic [DW-1:0] remainder
);
    import idiv_pkg::*;

    idiv_state_e   state_r, state_n;
    logic [CW-1:0] cnt_r;
    logic [1:0]    size_r;
    logic          sgn_r, negq_r, negr_r;
    logic          accept, load, step, fix_en;

    logic [NW-1:0] aligned;
    logic [DW-1:0] dvs_mag;
    logic          neg_q, neg_r, zero_div;
    logic [CW-1:0] iters;
    logic [NW-1:0] qmag;
    logic [DW-1:0] rmag;
    logic [DW-1:0] fq, fr;
    logic          ovf;

    idiv_operand_prep #(.DW(DW)) prep_i (
        .dividend (dividend),
        .divisor  (divisor),
        .size     (size),
        .is_signed(is_signed),
        .aligned  (aligned),
        .dvs_mag  (dvs_mag),
        .neg_q    (neg_q),
        .neg_r    (neg_r),
        .zero_div (zero_div),
        .iters    (iters)
    );

    idiv_shift_sub #(.DW(DW)) core_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .step   (step),
        .aligned(aligned),
        .dvs    (dvs_mag),
        .qmag   (qmag),
        .rmag   (rmag)
    );

    idiv_result_fix #(.DW(DW)) fix_i (
        .qmag     (qmag),
        .rmag     (rmag),
        .size     (size_r),
        .is_signed(sgn_r),
        .neg_q    (negq_r),
        .neg_r    (negr_r),
        .quo      (fq),
        .rem      (fr),
        .ovf      (ovf)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_r <= ST_IDLE;
        else        state_r <= state_n;
    end

    // Next state and control outputs
    always_comb begin
        state_n = state_r;
        busy    = 1'b0;
        done    = 1'b0;
        accept  = 1'b0;
        load    = 1'b0;
        step    = 1'b0;
        fix_en  = 1'b0;
        unique case (state_r)
            ST_IDLE: begin
                if (start) begin
                    accept = 1'b1;
                    if (zero_div) begin
                        state_n = ST_DONE;
                    end else begin
                        load    = 1'b1;
                        state_n = ST_RUN;
                    end
                end
            end
            ST_RUN: begin
                busy = 1'b1;
                step = 1'b1;
                if (cnt_r == CW'(1)) state_n = ST_FIX;
            end
            ST_FIX: begin
                busy    = 1'b1;
                fix_en  = 1'b1;
                state_n = ST_DONE;
            end
            ST_DONE: begin
                busy    = 1'b1;
                done    = 1'b1;
                state_n = ST_IDLE;
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // Step counter and operation context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_r  <= '0;
            size_r <= '0;
            sgn_r  <= 1'b0;
            negq_r <= 1'b0;
            negr_r <= 1'b0;
        end else if (load) begin
            cnt_r  <= iters;
            size_r <= size;
            sgn_r  <= is_signed;
            negq_r <= neg_q;
            negr_r <= neg_r;
        end else if (step) begin
            cnt_r <= cnt_r - CW'(1);
        end
    end

    // Result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_err   <= 1'b0;
            quotient  <= '0;
            remainder <= '0;
        end else if (accept) begin
            div_err   <= zero_div;
            quotient  <= '0;
            remainder <= '0;
        end else if (fix_en) begin
            div_err   <= ovf;
            quotient  <= ovf ? '0 : fq;
            remainder <= ovf ? '0 : fr;
        end
    end

endmodule

// File: rtl/idiv_checker.sv
module idiv_checker #(
    parameter int unsigned DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic [DW-1:0] divisor,
    input logic [1:0]    size,
    input logic          busy,
    input logic          done,
    input logic          div_err,
    input logic [DW-1:0] quotient,
    input logic [DW-1:0] remainder
);
    logic [DW-1:0] dmask;
    always_comb begin
        case (size)
            2'b00:   dmask = DW'((64'd1 << (DW / 4)) - 64'd1);
            2'b01:   dmask = DW'((64'd1 << (DW / 2)) - 64'd1);
            default: dmask = '1;
        endcase
    end

    AST_ZERO_DIV_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy && ((divisor & dmask) == '0) |=> done && div_err); // R5

    AST_ERR_ZERO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        done && div_err |-> quotient == '0 && remainder == '0); // R8

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9

    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy && ((divisor & dmask) != '0) |=> busy && !done); // R10

    AST_DONE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy); // R10

    AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy); // R10

    AST_NO_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !done |=> busy); // R11

    AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !start |=> $stable(quotient) && $stable(remainder) && $stable(div_err)); // R12

endmodule

bind int_divider idiv_checker #(.DW(DW)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .divisor  (divisor),
    .size     (size),
    .busy     (busy),
    .done     (done),
    .div_err  (div_err),
    .quotient (quotient),
    .remainder(remainder)
);

// File: tb/int_divider_tb_top.sv
`timescale 1ns/1ps
module int_divider_tb_top;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [63:0]   dividend = '0;
    logic [31:0]   divisor = '0;
    logic [1:0]    size = 2'b00;
    logic          is_signed = 1'b0;
    logic          busy, done, div_err;
    logic [31:0]   quotient, remainder;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] exp_q, exp_r;
    logic        exp_e;

    always #2.5 clk = ~clk;

    int_divider #(.DW(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend),
        .divisor(divisor), .size(size), .is_signed(is_signed),
        .busy(busy), .done(done), .div_err(div_err),
        .quotient(quotient), .remainder(remainder)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    // Behavioural reference using the language's own division operators.
    task automatic ref_div(input logic [63:0] dd, input logic [31:0] ds,
                           input logic [1:0] sz, input logic sg,
                           output logic [31:0] q, output logic [31:0] r, output logic e);
        int w;
        logic [63:0] m2, m1, a, b, qq, rr, qs, rs;
        logic sd, sv;
        w  = (sz == 2'b00) ? 8 : (sz == 2'b01) ? 16 : 32;
        m2 = (w == 32) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << (2 * w)) - 1);
        m1 = (64'd1 << w) - 1;
        a  = dd & m2;
        b  = {32'd0, ds} & m1;
        e = 1'b0; q = '0; r = '0;
        if (b == 0) begin
            e = 1'b1;
            return;
        end
        sd = sg && a[2 * w - 1];
        sv = sg && b[w - 1];
        if (sd) a = (-a) & m2;
        if (sv) b = (-b) & m1;
        qq = a / b;
        rr = a % b;
        if (!sg) e = qq >= (64'd1 << w);
        else if (sd ^ sv) e = qq > (64'd1 << (w - 1));
        else e = qq >= (64'd1 << (w - 1));
        if (e) return;
        qs = (sd ^ sv) ? -qq : qq;
        rs = sd ? -rr : rr;
        q = 32'(qs & m1);
        r = 32'(rs & m1);
    endtask

    // Runs one operation, comparing busy/done on every clock.
    task automatic run_div(input logic [63:0] dd, input logic [31:0] ds,
                           input logic [1:0] sz, input logic sg,
                           input bit poke, input string req);
        int w, lat;
        w = (sz == 2'b00) ? 8 : (sz == 2'b01) ? 16 : 32;
        ref_div(dd, ds, sz, sg, exp_q, exp_r, exp_e);
        lat = ((ds & 32'((64'd1 << w) - 1)) == 0) ? 0 : 2 * w + 1;
        @(negedge clk);
        dividend = dd; divisor = ds; size = sz; is_signed = sg; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k <= lat; k++) begin
            if (k > 0) @(negedge clk);
            check(busy === 1'b1, "R10", "busy during run", 64'(busy), 64'd1);
            check(done === (k == lat), "R9", $sformatf("done at step %0d", k),
                  64'(done), 64'(k == lat));
            if (poke && k == 2) begin
                start = 1'b1; dividend = 64'h1; divisor = 32'h1; is_signed = ~sg;
            end
            if (poke && k == 3) start = 1'b0;
        end
        check(div_err === exp_e, req, "div_err", 64'(div_err), 64'(exp_e));
        check(quotient === exp_q, req, "quotient", 64'(quotient), 64'(exp_q));
        check(remainder === exp_r, req, "remainder", 64'(remainder), 64'(exp_r));
        @(negedge clk);
        check(busy === 1'b0 && done === 1'b0, "R10", "idle after done",
              64'({busy, done}), 64'd0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        check(busy === 0 && done === 0 && div_err === 0 && quotient === 0 && remainder === 0,
              "R12", "reset state", {busy, done, div_err, quotient[0], remainder[0]}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        run_div(64'd1000, 32'd7, 2'b00, 1'b0, 0, "R2");              // 142 r 6
        run_div(64'h0012_3456, 32'h1234, 2'b01, 1'b0, 0, "R2");
        run_div(64'h0000_0005_0000_0000, 32'h10, 2'b10, 1'b0, 0, "R2");
        run_div(64'hDEAD_BEEF_0000_FF9C, 32'hABCD_0007, 2'b00, 1'b1, 0, "R3"); // -100/7
        run_div(64'h0000_03E8, 32'h0000_FFDF, 2'b01, 1'b1, 0, "R4");  // 1000/-33
        run_div(64'hFFFF_FFFF_FFFF_FFF9, 32'hFFFF_FFFE, 2'b11, 1'b1, 0, "R4"); // -7/-2
        run_div(64'h1234, 32'hFFFF_FF00, 2'b00, 1'b0, 0, "R5");       // low byte zero
        run_div(64'h0100, 32'h1, 2'b00, 1'b0, 0, "R6");              // 256 overflows
        run_div(64'h00FF, 32'h1, 2'b00, 1'b0, 0, "R6");              // 255 fits
        run_div(64'hFF80, 32'hFF, 2'b00, 1'b1, 0, "R7");             // -128/-1
        run_div(64'hFF80, 32'h01, 2'b00, 1'b1, 0, "R7");             // -128 legal
        run_div(64'hFFFF_FFFF_8000_0000, 32'h1, 2'b10, 1'b1, 0, "R7");
        run_div(64'h0000_0000_8000_0000, 32'h1, 2'b10, 1'b1, 0, "R7");
        run_div(64'h0000_0200, 32'h2, 2'b00, 1'b0, 0, "R8");
        run_div(64'hFFFF_FFFF_0001_0064, 32'hFFFF_000A, 2'b01, 1'b0, 0, "R1");
        run_div(64'hAAAA_5555_0000_0063, 32'h5555_0009, 2'b00, 1'b0, 0, "R1");
        run_div(64'd12345, 32'd100, 2'b01, 1'b0, 1, "R11");

        // R12: results hold while idle with changing inputs
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            dividend = 64'(i * 77); divisor = 32'(i); is_signed = i[0];
            check(quotient === exp_q && remainder === exp_r && div_err === exp_e,
                  "R12", "hold while idle", {quotient, remainder}, {exp_q, exp_r});
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule